// File: doc/BRIEF.md
# Flash Converter Thermometer Encoder Back-End

This block is the digital half of an 8-bit parallel-comparator converter. It takes 255 comparator decisions that form a thermometer code, plus one extra top comparator that flags an over-range input. It turns them into an 8-bit binary word and an over-range flag. The work is split across the two halves of the clock. The comparator decisions are latched on the rising edge. The first encoding stage runs while the clock is high and finds which 16-bit segment holds the top of the code. The second stage runs while the clock is low, picks the bit inside that segment, and loads the output register on the next falling edge. A word that is present at a rising edge therefore appears on the outputs one and a half cycles later, and a new word can enter on every cycle.

A code with bubbles is resolved by its highest asserted comparator. When the over-range comparator is set, the data word saturates. Two enables of opposite polarity control the outputs. The active-high enable gates every output. The active-low enable gates only the data bits, so the over-range flag can stay visible while the data bus is released.

Top module: `flash_backend`

## Requirements
- R1: While rst_ni is low, every pipeline and output register is cleared, whatever the inputs are. With both outputs enabled, data_o reads 0 and ovf_o reads 0.
- R2: A clean thermometer code with its k lowest bits set (bit 0 is the lowest comparator, 0 <= k <= 255) and ovf_cmp_i low gives data_o = k.
- R3: A code with bubbles gives data_o = 1 + (index of the highest set bit of therm_i). An all-zero code gives 0.
- R4: When ovf_cmp_i is high, ovf_o is 1 and data_o is 8'hFF, whatever therm_i holds.
- R5: Inputs present at a rising edge appear on the outputs at the falling edge one and a half cycles later. The outputs change only on falling edges.
- R6: The pipeline accepts a new input word on every clock cycle, and each word comes out in order with no gaps.
- R7: With ce1_ni=0 and ce2_i=1, both data_o and ovf_o are driven.
- R8: With ce1_ni=1 and ce2_i=1, data_o is high impedance and ovf_o stays driven.
- R9: With ce2_i=0, data_o and ovf_o are both high impedance, whatever ce1_ni is.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Clock. The high half is phase 1 and the low half is phase 2. |
| rst_ni | input | 1 | Asynchronous reset, active low |
| therm_i | input | 255 | Comparator decisions. Bit i is set when the input lies above tap i. |
| ovf_cmp_i | input | 1 | Over-range comparator decision |
| ce1_ni | input | 1 | Data-bus enable, active low |
| ce2_i | input | 1 | Global output enable, active high |
| data_o | output | 8 | Binary conversion result, tri-state |
| ovf_o | output | 1 | Over-range flag, tri-state |

## Verification
The hardest case to reach is a word entering the pipeline while the previous two are still in flight. A fault in the half-cycle hand-off would only show up there. The stimulus therefore streams one new vector per cycle: a full sweep of clean codes, then one bubbled code for every possible top index with random bits below it. Each output is checked both just after the falling edge where it lands and again during the following high phase. High impedance is told apart from a driven value by weak pull-ups on the bench nets, while the DUT drives a result that is not all ones.

// File: rtl/flash_enc_pkg.sv
package flash_enc_pkg;
  localparam int unsigned RES_DEF = 8;
  localparam int unsigned SEG_BITS_DEF = 4;

  typedef enum logic [1:0] {
    OE_NONE = 2'b00,
    OE_OVF  = 2'b01,
    OE_ALL  = 2'b11
  } oe_mode_e;

  function automatic oe_mode_e decode_oe(input logic ce1_n, input logic ce2);
    if (!ce2)  return OE_NONE;
    if (ce1_n) return OE_OVF;
    return OE_ALL;
  endfunction
endpackage

// File: rtl/prio_hi.sv
module prio_hi #(
  parameter int unsigned W  = 16,
  localparam int unsigned IW = (W > 1) ? $clog2(W) : 1
) (
  input  logic [W-1:0]  vec_i,
  output logic [IW-1:0] idx_o
);
  always_comb begin
    idx_o = '0;
    for (int i = 0; i < W; i++) begin
      if (vec_i[i]) idx_o = IW'(i);
    end
  end
endmodule

// File: rtl/therm_coarse.sv
module therm_coarse #(
  parameter int unsigned RES      = 8,
  parameter int unsigned SEG_BITS = 4,
  localparam int unsigned EXT_W   = 1 << RES,
  localparam int unsigned SEG_W   = 1 << SEG_BITS,
  localparam int unsigned CB      = RES - SEG_BITS,
  localparam int unsigned NSEG    = 1 << CB
) (
  input  logic [EXT_W-1:0] ext_i,
  output logic [CB-1:0]    seg_idx_o,
  output logic [SEG_W-1:0] seg_bits_o
);
  logic [NSEG-1:0] seg_any;

  for (genvar s = 0; s < NSEG; s++) begin : g_seg
    assign seg_any[s] = |ext_i[s*SEG_W +: SEG_W];
  end

  prio_hi #(.W(NSEG)) u_coarse (
    .vec_i (seg_any),
    .idx_o (seg_idx_o)
  );

  assign seg_bits_o = ext_i[seg_idx_o*SEG_W +: SEG_W];
endmodule

// File: rtl/oe_drv.sv
module oe_drv #(
  parameter int unsigned W = 8
) (
  input  logic         en_i,
  input  logic [W-1:0] d_i,
  output wire  [W-1:0] q_o
);
  assign q_o = en_i ? d_i : {W{1'bz}};
endmodule

// File: rtl/flash_backend.sv
module flash_backend
  import flash_enc_pkg::*;
#(
  parameter int unsigned RES      = RES_DEF,
  parameter int unsigned SEG_BITS = SEG_BITS_DEF,
  localparam int unsigned THERM_W = (1 << RES) - 1,
  localparam int unsigned SEG_W   = 1 << SEG_BITS,
  localparam int unsigned CB      = RES - SEG_BITS
) (
  input  logic               clk_i,
  input  logic               rst_ni,
  input  logic [THERM_W-1:0] therm_i,
  input  logic               ovf_cmp_i,
  input  logic               ce1_ni,
  input  logic               ce2_i,
  output wire  [RES-1:0]     data_o,
  output wire                ovf_o
);
  // rising edge: latch comparator decisions
  logic [THERM_W-1:0] samp_therm_q;
  logic               samp_ovf_q;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      samp_therm_q <= '0;
      samp_ovf_q   <= 1'b0;
    end else begin
      samp_therm_q <= therm_i;
      samp_ovf_q   <= ovf_cmp_i;
    end
  end

  // phase 1: coarse segment search; bit 0 of ext stands for "zero taps"
  logic [CB-1:0]    seg_idx;
  logic [SEG_W-1:0] seg_bits;

  therm_coarse #(.RES(RES), .SEG_BITS(SEG_BITS)) u_coarse (
    .ext_i      ({samp_therm_q, 1'b1}),
    .seg_idx_o  (seg_idx),
    .seg_bits_o (seg_bits)
  );

  logic [CB-1:0]    part_idx_q;
  logic [SEG_W-1:0] part_bits_q;
  logic             part_ovf_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      part_idx_q  <= '0;
      part_bits_q <= '0;
      part_ovf_q  <= 1'b0;
    end else begin
      part_idx_q  <= seg_idx;
      part_bits_q <= seg_bits;
      part_ovf_q  <= samp_ovf_q;
    end
  end

  // phase 2: fine position inside the selected segment
  logic [SEG_BITS-1:0] fine_idx;
  logic [RES-1:0]      code;

  prio_hi #(.W(SEG_W)) u_fine (
    .vec_i (part_bits_q),
    .idx_o (fine_idx)
  );

  assign code = part_ovf_q ? {RES{1'b1}} : {part_idx_q, fine_idx};

  logic [RES-1:0] out_data_q;
  logic           out_ovf_q;

  always_ff @(negedge clk_i or negedge rst_ni) begin
    if (!rst_ni) begin
      out_data_q <= '0;
      out_ovf_q  <= 1'b0;
    end else begin
      out_data_q <= code;
      out_ovf_q  <= part_ovf_q;
    end
  end

  oe_mode_e oe_mode;
  assign oe_mode = decode_oe(ce1_ni, ce2_i);

  oe_drv #(.W(RES)) u_drv_data (
    .en_i (oe_mode == OE_ALL),
    .d_i  (out_data_q),
    .q_o  (data_o)
  );

  oe_drv #(.W(1)) u_drv_ovf (
    .en_i (oe_mode != OE_NONE),
    .d_i  (out_ovf_q),
    .q_o  (ovf_o)
  );
endmodule

// File: rtl/flash_backend_chk.sv
module flash_backend_chk #(
  parameter int unsigned RES = 8,
  localparam int unsigned TW = (1 << RES) - 1
) (
  input logic          clk_i,
  input logic          rst_ni,
  input logic [TW-1:0] therm_i,
  input logic          ovf_cmp_i,
  input logic          ce1_ni,
  input logic          ce2_i,
  input logic [RES-1:0] data_o,
  input logic          ovf_o
);
  logic [1:0] cyc_q;
  logic [RES:0] cnt;
  logic [TW:0]  ones_lim;
  logic         clean;

  always_ff @(posedge clk_i or negedge rst_ni) begin
    if (!rst_ni)            cyc_q <= '0;
    else if (cyc_q != 2'd3) cyc_q <= cyc_q + 2'd1;
  end

  assign cnt      = (RES+1)'($countones(therm_i));
  assign ones_lim = (TW+1)'(1) << cnt;
  assign clean    = (therm_i == ones_lim[TW-1:0] - TW'(1)) || (cnt == (RES+1)'(TW));

  // R1
  always @(posedge clk_i) begin
    if (!rst_ni && ce2_i) begin
      rst_clear_chk: assert (ovf_o == 1'b0);
    end
  end

  // R2
  clean_count_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && ce2_i && !ce1_ni && !$past(ovf_cmp_i, 2) && $past(clean, 2))
      |-> data_o == $past(cnt[RES-1:0], 2));

  // R4
  ovf_saturate_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (ce2_i && !ce1_ni && ovf_o == 1'b1) |-> data_o == {RES{1'b1}});

  // R5
  ovf_latency_chk: assert property (@(posedge clk_i) disable iff (!rst_ni)
    (cyc_q >= 2'd2 && ce2_i) |-> ovf_o == $past(ovf_cmp_i, 2));
endmodule

bind flash_backend flash_backend_chk #(.RES(RES)) u_chk (
  .clk_i     (clk_i),
  .rst_ni    (rst_ni),
  .therm_i   (therm_i),
  .ovf_cmp_i (ovf_cmp_i),
  .ce1_ni    (ce1_ni),
  .ce2_i     (ce2_i),
  .data_o    (data_o),
  .ovf_o     (ovf_o)
);

// File: tb/tb_flash_backend.sv
`timescale 1ns/1ps
module tb_flash_backend;
  localparam int TW = 255;

  logic          clk_i = 1'b0;
  logic          rst_ni = 1'b0;
  logic [TW-1:0] therm_i = '0;
  logic          ovf_cmp_i = 1'b0;
  logic          ce1_ni = 1'b0;
  logic          ce2_i = 1'b1;
  tri1  [7:0]    data_w;
  tri1           ovf_w;

  int n_chk = 0;
  int n_bad = 0;
  logic [31:0] rng = 32'h1234_5678;

  always #5 clk_i = ~clk_i;

  flash_backend dut (
    .clk_i     (clk_i),
    .rst_ni    (rst_ni),
    .therm_i   (therm_i),
    .ovf_cmp_i (ovf_cmp_i),
    .ce1_ni    (ce1_ni),
    .ce2_i     (ce2_i),
    .data_o    (data_w),
    .ovf_o     (ovf_w)
  );

  task automatic check(input string rq, input logic [7:0] ad, input logic ao,
                       input logic [7:0] ed, input logic eo);
    n_chk++;
    if (ad !== ed || ao !== eo) begin
      n_bad++;
      $display("FAIL %s actual data=%h ovf=%b expected data=%h ovf=%b", rq, ad, ao, ed, eo);
    end
  endtask

  // two-deep history of words in flight
  logic [7:0] h1_d, h2_d;
  logic       h1_o, h2_o, h1_v = 1'b0, h2_v = 1'b0;
  string      h1_r, h2_r;

  // R5 R6: one new word per cycle, checked after its falling edge and during next high phase
  task automatic step(input logic [TW-1:0] t, input logic o, input logic [7:0] ed,
                      input logic eo, input string rq);
    @(negedge clk_i); #2;
    if (h2_v) check({h2_r, " R6"}, data_w, ovf_w, h2_d, h2_o);
    therm_i = t; ovf_cmp_i = o;
    @(posedge clk_i); #2;
    if (h2_v) check({h2_r, " R5 stable in phase 1"}, data_w, ovf_w, h2_d, h2_o);
    h2_d = h1_d; h2_o = h1_o; h2_v = h1_v; h2_r = h1_r;
    h1_d = ed;   h1_o = eo;   h1_v = 1'b1; h1_r = rq;
  endtask

  function automatic logic [31:0] nxt(input logic [31:0] x);
    logic [31:0] y;
    y = x ^ (x << 13);
    y = y ^ (y >> 17);
    return y ^ (y << 5);
  endfunction

  initial begin
    #1_000_000;
    n_bad++;
    $display("FAIL R6 watchdog actual=hung expected=finished");
    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end

  initial begin
    // R1: busy inputs during reset must not leak through
    therm_i = '1; ovf_cmp_i = 1'b1;
    repeat (3) @(negedge clk_i);
    #2;
    check("R1", data_w, ovf_w, 8'h00, 1'b0);
    @(posedge clk_i); #2;
    check("R1", data_w, ovf_w, 8'h00, 1'b0);
    therm_i = '0; ovf_cmp_i = 1'b0;
    @(negedge clk_i); #2;
    rst_ni = 1'b1;

    // R2: every clean count
    for (int k = 0; k <= TW; k++) begin
      logic [TW:0] m;
      m = ((TW+1)'(1) << k) - (TW+1)'(1);
      step(m[TW-1:0], 1'b0, 8'(k), 1'b0, "R2");
    end

    // R3: bubbles below each possible top index
    for (int h = 0; h < TW; h++) begin
      logic [TW-1:0] p;
      for (int w = 0; w < 8; w++) begin
        rng = nxt(rng);
        for (int b = 0; b < 32; b++) if (w*32 + b < TW) p[w*32+b] = rng[b];
      end
      for (int i = 0; i < TW; i++) if (i > h) p[i] = 1'b0;
      p[h] = 1'b1;
      step(p, 1'b0, 8'(h + 1), 1'b0, "R3");
    end
    step('0, 1'b0, 8'h00, 1'b0, "R3 all zero");

    // R4: over-range saturates regardless of the code
    step('0, 1'b1, 8'hFF, 1'b1, "R4");
    step({{(TW-17){1'b0}}, {17{1'b1}}}, 1'b1, 8'hFF, 1'b1, "R4");
    step({{(TW-128){1'b0}}, {128{1'b1}}}, 1'b1, 8'hFF, 1'b1, "R4");
    step('1, 1'b1, 8'hFF, 1'b1, "R4");
    step({{(TW-53){1'b0}}, {53{1'b1}}}, 1'b0, 8'd53, 1'b0, "R2");
    step({{(TW-53){1'b0}}, {53{1'b1}}}, 1'b0, 8'd53, 1'b0, "R2");
    step({{(TW-53){1'b0}}, {53{1'b1}}}, 1'b0, 8'd53, 1'b0, "R2");

    // enable truth table; a released net reads as all ones through the pull-ups
    @(negedge clk_i); #2;
    ce1_ni = 1'b0; ce2_i = 1'b1; #1;
    check("R7", data_w, ovf_w, 8'd53, 1'b0);
    ce1_ni = 1'b1; ce2_i = 1'b1; #1;
    check("R8", data_w, ovf_w, 8'hFF, 1'b0);
    ce1_ni = 1'b0; ce2_i = 1'b0; #1;
    check("R9", data_w, ovf_w, 8'hFF, 1'b1);
    ce1_ni = 1'b1; ce2_i = 1'b0; #1;
    check("R9", data_w, ovf_w, 8'hFF, 1'b1);
    ce1_ni = 1'b0; ce2_i = 1'b1; #1;
    check("R7", data_w, ovf_w, 8'd53, 1'b0);

    $display("== %0d vectors applied, %0d miscompares ==", n_chk, n_bad);
    $finish;
  end
endmodule